// File: doc/BRIEF.md
# Protected-Mode Segment Access Checker

This block screens a single memory access against a segment descriptor that has already been cached, and produces the linear address for that access. Each cycle the requester presents the processor mode, the kind of access, the segment index in use, the access size, the 32-bit offset and the cached descriptor: its valid bit, base, limit and type bits. One cycle later the block returns a result. The result is either a linear address with no fault, or a fault strobe together with a fault class.

There are two fault classes: a stack fault and a general-protection fault. Whether a failed check reports one class or the other depends on which segment the access used and on which check failed. The checks are only performed in protected mode outside virtual-8086 operation, and only for read and write accesses. Fetches and accesses marked unchecked skip every check. Loading descriptors, holding the segment registers and delivering exceptions are left to neighbouring logic.

Top module: `seg_access_check`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `fault_valid`, `fault_class` and `lin_addr` are all zero.
- R2: Every result appears exactly one clock after its request. `out_valid` repeats `req_valid` with one cycle of delay. `fault_valid` is high for one cycle only, and only for a request that faults. In a cycle with no result, `lin_addr` is zero and `fault_class` is 0.
- R3: No check is performed, and no fault is raised, when any of the following holds: `prot_en` is 0, `v86_en` is 1, or `acc_kind` is 0 (unchecked) or 3 (fetch). In those cases only the address is formed.
- R4: A checked access whose descriptor has `desc_valid` = 0 faults. The fault class is 1 (stack fault) when `seg_idx` equals 2, the stack segment. For any other index the class is 0 (general protection).
- R5: The access size comes from `acc_size`: code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. The last byte touched is offset + bytes − 1, computed without wraparound. A checked access faults when that last byte is greater than `desc_limit`. The fault class is chosen as in R4.
- R6: A checked read (`acc_kind` = 1) faults with class 0 when `desc_type[3]` (code segment) is 1 and `desc_type[1]` (readable) is 0.
- R7: A checked write (`acc_kind` = 2) faults with class 0 when `desc_type[3]` is 1, or when `desc_type[1]` (writable) is 0.
- R8: The checks run in a fixed order: descriptor validity, then limit, then type. Only the first check that fails sets the fault class. As a result, an access on the stack segment that fails both the limit check and the type check reports class 1.
- R9: For a result without a fault, `lin_addr` equals `desc_base` + offset, taken modulo 2^32.
- R10: For a result with a fault, `lin_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| prot_en | input | 1 | Protected mode active |
| v86_en | input | 1 | Virtual-8086 mode active |
| acc_kind | input | 2 | 0 unchecked, 1 read, 2 write, 3 fetch |
| acc_size | input | 2 | 0 one byte, 1 two bytes, 2/3 four bytes |
| seg_idx | input | 3 | Segment index used by the access (2 = stack) |
| offset | input | 32 | Offset within the segment |
| desc_valid | input | 1 | Cached descriptor is usable |
| desc_base | input | 32 | Descriptor base |
| desc_limit | input | 32 | Descriptor limit (last legal byte offset) |
| desc_type | input | 4 | Descriptor type bits; bit 3 code, bit 1 readable/writable |
| out_valid | output | 1 | Result valid, one cycle after request |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_class | output | 1 | 1 stack fault, 0 general protection |
| lin_addr | output | 32 | Linear address, zero on fault |

## Verification
The bench instantiates the block with its default parameters: a 32-bit address width, stack segment index 2, and code and read/write flags at type bits 3 and 1. Because the address width is 32 bits, two corner cases can be driven directly. The first is a base plus offset that wraps past 2^32. The second is an access whose last byte lies beyond 0xFFFFFFFF, which must fault even when the limit is at its maximum. With index 2 as the stack segment, the bench can put an invalid descriptor, a limit fault and a type fault on the same segment. This shows that the fault class follows the priority order rather than the segment alone.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_RD    = 2'd1,
    ACC_WR    = 2'd2,
    ACC_FETCH = 2'd3
  } acc_kind_e;

  typedef enum logic {
    FC_GP = 1'b0,
    FC_SS = 1'b1
  } fault_cls_e;

  typedef enum logic [1:0] {
    FS_NONE  = 2'd0,
    FS_DESC  = 2'd1,
    FS_LIMIT = 2'd2,
    FS_TYPE  = 2'd3
  } fault_src_e;

  // Number of bytes covered by a size code.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // Only reads and writes are screened; fetch and unchecked pass through.
  function automatic logic kind_checked(input logic [1:0] kind);
    kind_checked = (kind == ACC_RD) || (kind == ACC_WR);
  endfunction

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] offset,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] limit,
  output logic          over_limit
);
  import seg_chk_pkg::*;

  localparam int LW = AW + 1;

  // Last byte offset, one bit wider so a run past the top never wraps.
  function automatic logic [LW-1:0] last_byte(input logic [AW-1:0] off,
                                              input logic [1:0]    sc);
    logic [LW-1:0] nb;
    nb = LW'(size_bytes(sc));
    last_byte = {1'b0, off} + nb - LW'(1);
  endfunction

  logic [LW-1:0] last_off;

  always_comb begin
    last_off   = last_byte(offset, size_code);
    over_limit = last_off > {1'b0, limit};
  end

endmodule

// File: rtl/seg_type_unit.sv
module seg_type_unit #(
  parameter int TYPE_W   = 4,
  parameter int CODE_BIT = 3,
  parameter int RW_BIT   = 1
) (
  input  logic [1:0]        kind,
  input  logic [TYPE_W-1:0] dtype,
  output logic              type_fail
);
  import seg_chk_pkg::*;

  logic is_code;
  logic rw_ok;
  logic rd_bad;
  logic wr_bad;

  always_comb begin
    is_code   = dtype[CODE_BIT];
    rw_ok     = dtype[RW_BIT];
    // Execute-only code cannot be read.
    rd_bad    = (kind == ACC_RD) && is_code && !rw_ok;
    // Code is never writable; data must carry the writable flag.
    wr_bad    = (kind == ACC_WR) && (is_code || !rw_ok);
    type_fail = rd_bad || wr_bad;
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] lin
);

  // Modular sum; the carry out of the top bit is discarded.
  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    wrap_add = a + b;
  endfunction

  always_comb lin = wrap_add(base, offset);

endmodule

// File: rtl/seg_fault_select.sv
module seg_fault_select (
  input  logic                    checks_on,
  input  logic                    desc_ok,
  input  logic                    over_limit,
  input  logic                    type_fail,
  input  logic                    is_stack,
  output logic                    fault,
  output seg_chk_pkg::fault_cls_e cls,
  output seg_chk_pkg::fault_src_e src
);
  import seg_chk_pkg::*;

  // Ordered selection: the first failing check decides the class.
  always_comb begin
    src = FS_NONE;
    if (checks_on) begin
      if (!desc_ok)        src = FS_DESC;
      else if (over_limit) src = FS_LIMIT;
      else if (type_fail)  src = FS_TYPE;
    end
    fault = (src != FS_NONE);
    case (src)
      FS_DESC, FS_LIMIT: cls = is_stack ? FC_SS : FC_GP;
      default:           cls = FC_GP;
    endcase
  end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int AW        = 32,
  parameter int SEG_W     = 3,
  parameter int STACK_SEG = 2,
  parameter int TYPE_W    = 4,
  parameter int CODE_BIT  = 3,
  parameter int RW_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              prot_en,
  input  logic              v86_en,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic [SEG_W-1:0]  seg_idx,
  input  logic [AW-1:0]     offset,
  input  logic              desc_valid,
  input  logic [AW-1:0]     desc_base,
  input  logic [AW-1:0]     desc_limit,
  input  logic [TYPE_W-1:0] desc_type,
  output logic              out_valid,
  output logic              fault_valid,
  output logic              fault_class,
  output logic [AW-1:0]     lin_addr
);
  import seg_chk_pkg::*;

  localparam logic [SEG_W-1:0] STACK_ID = SEG_W'(STACK_SEG);

  // Named internal events, visible to the assertions below.
  logic        checks_on;
  logic        is_stack;
  logic        over_limit;
  logic        type_fail;
  logic        any_fault;
  fault_cls_e  sel_cls;
  fault_src_e  sel_src;
  logic [AW-1:0] sum_addr;
  logic        take_fault;

  always_comb begin
    checks_on  = prot_en && !v86_en && kind_checked(acc_kind);
    is_stack   = (seg_idx == STACK_ID);
    take_fault = req_valid && any_fault;
  end

  seg_limit_unit #(.AW(AW)) u_limit (
    .offset     (offset),
    .size_code  (acc_size),
    .limit      (desc_limit),
    .over_limit (over_limit)
  );

  seg_type_unit #(.TYPE_W(TYPE_W), .CODE_BIT(CODE_BIT), .RW_BIT(RW_BIT)) u_type (
    .kind      (acc_kind),
    .dtype     (desc_type),
    .type_fail (type_fail)
  );

  seg_addr_gen #(.AW(AW)) u_addr (
    .base   (desc_base),
    .offset (offset),
    .lin    (sum_addr)
  );

  seg_fault_select u_sel (
    .checks_on  (checks_on),
    .desc_ok    (desc_valid),
    .over_limit (over_limit),
    .type_fail  (type_fail),
    .is_stack   (is_stack),
    .fault      (any_fault),
    .cls        (sel_cls),
    .src        (sel_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      fault_valid <= 1'b0;
      fault_class <= 1'b0;
      lin_addr    <= '0;
    end else begin
      out_valid   <= req_valid;
      fault_valid <= take_fault;
      fault_class <= take_fault ? sel_cls : FC_GP;
      lin_addr    <= (req_valid && !any_fault) ? sum_addr : '0;
    end
  end

  // R2: a fault strobe only ever accompanies a result
  a_r2_fault_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> out_valid);

  // R3: bypassed accesses never fault
  a_r3_bypass_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !checks_on) |=> !fault_valid);

  // R4: an invalid descriptor on a checked access always faults
  a_r4_invalid_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && checks_on && !desc_valid) |=> fault_valid);

  // R7: a type-only failure reports general protection
  a_r7_type_is_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && checks_on && desc_valid && !over_limit && type_fail)
      |=> (fault_valid && fault_class == FC_GP));

  // R8: the stack class appears only for the stack segment
  a_r8_ss_only_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_stack) |=> (fault_class == FC_GP));

  // R10: a faulting result carries a zero address
  a_r10_addr_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (lin_addr == '0));

endmodule

// File: tb/seg_access_check_bench.sv
`timescale 1ns/1ps
module seg_access_check_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        prot_en = 1'b0;
  logic        v86_en = 1'b0;
  logic [1:0]  acc_kind = 2'd0;
  logic [1:0]  acc_size = 2'd0;
  logic [2:0]  seg_idx = 3'd0;
  logic [31:0] offset = '0;
  logic        desc_valid = 1'b0;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic [3:0]  desc_type = '0;
  logic        out_valid;
  logic        fault_valid;
  logic        fault_class;
  logic [31:0] lin_addr;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic        e_valid, e_fault, e_cls;
  logic [31:0] e_addr;

  always #2.5 clk = ~clk;

  seg_access_check u_seg_access_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_en(prot_en),
    .v86_en(v86_en), .acc_kind(acc_kind), .acc_size(acc_size),
    .seg_idx(seg_idx), .offset(offset), .desc_valid(desc_valid),
    .desc_base(desc_base), .desc_limit(desc_limit), .desc_type(desc_type),
    .out_valid(out_valid), .fault_valid(fault_valid),
    .fault_class(fault_class), .lin_addr(lin_addr)
  );

  // Behavioural reference, written from the requirements.
  task automatic model(input logic rv, input logic pe, input logic ve,
                       input int kind, input int sz, input int seg,
                       input longint off, input logic dv, input longint base,
                       input longint lim, input logic [3:0] t);
    longint last;
    int nbytes;
    logic chk;
    e_valid = rv; e_fault = 0; e_cls = 0; e_addr = 0;
    if (!rv) return;
    chk = pe && !ve && (kind == 1 || kind == 2);
    nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    last = off + nbytes - 1;
    if (chk) begin
      if (!dv) begin e_fault = 1; e_cls = (seg == 2); end
      else if (last > lim) begin e_fault = 1; e_cls = (seg == 2); end
      else if (kind == 1 && t[3] && !t[1]) e_fault = 1;
      else if (kind == 2 && (t[3] || !t[1])) e_fault = 1;
    end
    if (!e_fault) e_addr = 32'((base + off) % 64'h1_0000_0000);
  endtask

  task automatic check(input string tag);
    tests++;
    if (out_valid !== e_valid || fault_valid !== e_fault ||
        fault_class !== e_cls || lin_addr !== e_addr) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b c=%0b a=%h exp v=%0b f=%0b c=%0b a=%h",
               tag, out_valid, fault_valid, fault_class, lin_addr,
               e_valid, e_fault, e_cls, e_addr);
    end
  endtask

  // Drive at the falling edge, let one rising edge register, sample after.
  task automatic step(input string tag, input logic rv, input logic pe,
                      input logic ve, input int kind, input int sz,
                      input int seg, input logic [31:0] off, input logic dv,
                      input logic [31:0] base, input logic [31:0] lim,
                      input logic [3:0] t);
    @(negedge clk);
    req_valid = rv; prot_en = pe; v86_en = ve; acc_kind = 2'(kind);
    acc_size = 2'(sz); seg_idx = 3'(seg); offset = off; desc_valid = dv;
    desc_base = base; desc_limit = lim; desc_type = t;
    model(rv, pe, ve, kind, sz, seg, longint'(off), dv, longint'(base),
          longint'(lim), t);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      tests++; fails++;
      $display("FAIL watchdog: got cycles=%0d exp below 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    #12;
    e_valid = 0; e_fault = 0; e_cls = 0; e_addr = 0;
    check("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step("R1 idle after reset", 0, 1, 0, 1, 0, 0, 32'h0, 1, 32'h0, 32'hFFFF, 4'h2);

    // R3 / R9: bypass paths, including wraparound of the sum
    step("R9 wrap sum prot off", 1, 0, 0, 1, 2, 1, 32'h20, 0, 32'hFFFF_FFF0, 32'h0, 4'h8);
    step("R3 v86 skips checks", 1, 1, 1, 2, 2, 2, 32'h100, 0, 32'h1000, 32'h0, 4'h8);
    step("R3 unchecked kind 0", 1, 1, 0, 0, 2, 2, 32'h500, 0, 32'h10, 32'h0, 4'h8);
    step("R3 fetch kind 3", 1, 1, 0, 3, 2, 1, 32'h500, 0, 32'h10, 32'h0, 4'h8);
    step("R2 idle gives zero", 0, 1, 0, 1, 0, 2, 32'h0, 0, 32'h0, 32'h0, 4'h0);

    // R4: invalid descriptor class depends on segment
    step("R4 invalid stack seg", 1, 1, 0, 1, 0, 2, 32'h4, 0, 32'h100, 32'hFFFF, 4'h2);
    step("R4 invalid other seg", 1, 1, 0, 2, 0, 3, 32'h4, 0, 32'h100, 32'hFFFF, 4'h2);

    // R5: limit boundaries per size
    step("R5 byte at limit ok", 1, 1, 0, 1, 0, 1, 32'hFF, 1, 32'h1000, 32'hFF, 4'h2);
    step("R5 word ends at limit", 1, 1, 0, 1, 1, 1, 32'hFE, 1, 32'h1000, 32'hFF, 4'h2);
    step("R5 word past limit", 1, 1, 0, 1, 1, 1, 32'hFF, 1, 32'h1000, 32'hFF, 4'h2);
    step("R5 dword ends at limit", 1, 1, 0, 2, 2, 4, 32'hFC, 1, 32'h1000, 32'hFF, 4'h2);
    step("R5 dword past limit stack", 1, 1, 0, 2, 2, 2, 32'hFD, 1, 32'h1000, 32'hFF, 4'h2);
    step("R5 past top of space", 1, 1, 0, 1, 1, 1, 32'hFFFF_FFFF, 1, 32'h0, 32'hFFFF_FFFF, 4'h2);
    step("R5 size code 3 is four", 1, 1, 0, 1, 3, 1, 32'hFD, 1, 32'h0, 32'hFF, 4'h2);

    // R6: reads
    step("R6 read exec-only code", 1, 1, 0, 1, 0, 1, 32'h10, 1, 32'h2000, 32'hFFFF, 4'h8);
    step("R6 read readable code", 1, 1, 0, 1, 0, 1, 32'h10, 1, 32'h2000, 32'hFFFF, 4'hA);
    step("R6 read plain data", 1, 1, 0, 1, 0, 1, 32'h10, 1, 32'h2000, 32'hFFFF, 4'h0);

    // R7: writes
    step("R7 write writable data", 1, 1, 0, 2, 1, 1, 32'h10, 1, 32'h2000, 32'hFFFF, 4'h2);
    step("R7 write read-only data", 1, 1, 0, 2, 1, 1, 32'h10, 1, 32'h2000, 32'hFFFF, 4'h0);
    step("R7 write code", 1, 1, 0, 2, 1, 2, 32'h10, 1, 32'h2000, 32'hFFFF, 4'hA);

    // R8: priority on the stack segment
    step("R8 limit before type", 1, 1, 0, 2, 2, 2, 32'hFFF0, 1, 32'h0, 32'hFF, 4'h8);
    step("R8 valid before limit", 1, 1, 0, 2, 2, 2, 32'hFFF0, 0, 32'h0, 32'hFF, 4'h8);
    step("R8 type alone is GP", 1, 1, 0, 2, 0, 2, 32'h10, 1, 32'h0, 32'hFF, 4'h8);

    // R10 / R2: back-to-back fault then clean access
    step("R10 fault zeroes addr", 1, 1, 0, 1, 0, 1, 32'h10, 0, 32'h1234, 32'hFF, 4'h0);
    step("R2 next result clean", 1, 1, 0, 1, 0, 1, 32'h10, 1, 32'h1234, 32'hFF, 4'h0);

    // Mixed patterns against the reference, every cycle
    for (int i = 0; i < 400; i++) begin
      logic [31:0] o, l;
      o = $urandom;
      if ($urandom_range(0, 1) == 1) o = o & 32'hFF;
      l = o + 32'($urandom_range(0, 5)) - 32'd2;
      step("RND mixed", 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 5) == 0), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 5), o, 1'($urandom_range(0, 7) != 0), $urandom, l,
           4'($urandom_range(0, 15)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule